// File: doc/BRIEF.md
# Revolution Counter Range Monitor

This block sits beside a 16-bit revolution counter and watches each step the counter takes. For every step it receives the value before the step, the value after it, and whether the step counted up or down. It raises a sticky out-of-range flag when the counter crosses the edge of its allowed window. That edge is detected as one specific value transition in one specific direction, not by comparing the counter against a limit.

Two windows are available. In unsigned mode the window is the full range from zero to all-ones. In mid-scale mode the window is centred, so its edges lie where the top bit flips. Software sees a three-bit control word through a single write strobe and a read path. The word holds the flag, an interrupt enable and the mode select. The flag is cleared by writing zero to it. An interrupt request, registered one cycle, follows the flag gated by the enable.

Top module: `rev_range_monitor`

## Requirements
- R1: In unsigned mode (control bit 2 = 0), a down step from 0x0001 to 0x0000 sets the flag on that clock edge.
- R2: In unsigned mode, an up step (step_up = 1) from 0xFFFE to 0xFFFF sets the flag on that clock edge.
- R3: In mid-scale mode (control bit 2 = 1), a down step from 0x8001 to 0x8000 sets the flag.
- R4: In mid-scale mode, an up step from 0x7FFE to 0x7FFF sets the flag.
- R5: No other step leaves the flag changed. This covers the wrong direction, other values, a transition that belongs to the other mode, and any values presented while step_valid is 0.
- R6: A write with control bit 0 = 0 clears the flag. A write with bit 0 = 1 leaves the flag unchanged.
- R7: When a setting step and a clearing write fall in the same cycle, the flag ends up set.
- R8: While rmw_rd is 1, read bit 0 returns 1 whatever the flag holds. Otherwise read bit 0 returns the flag.
- R9: irq equals the flag AND the enable (control bit 1), as sampled one clock earlier.
- R10: After reset the flag, the enable, the mode and irq are 0. Read bits 15 to 3 always read 0.
- R11: A write loads control bit 1 into the enable and bit 2 into the mode, and both read back at the same positions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | Counter stepped this cycle |
| step_up | input | 1 | 1 = up step, 0 = down step |
| cnt_prev | input | 16 | Counter value before the step |
| cnt_next | input | 16 | Counter value after the step |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 3 | Bit 0 flag (0 clears), bit 1 enable, bit 2 mode |
| rmw_rd | input | 1 | Read belongs to a read-modify-write access |
| rd_data | output | 16 | Control word read value |
| range_flag | output | 1 | Sticky out-of-range flag |
| irq | output | 1 | Registered interrupt request |

## Verification
The assertions assume that step_valid, step_up and both counter values are stable and meaningful across each rising edge. They also assume that a write carries the enable and mode the caller wants to keep, because every write loads both fields. The stimulus changes inputs only on falling edges, and holds step_valid high for exactly one cycle per step. Each write re-sends the enable and mode that the test intends, so a clearing write never changes the mode by accident.

// File: rtl/rcm_pkg.sv
package rcm_pkg;

    localparam int CTL_W    = 3;
    localparam int RD_W     = 16;
    localparam int FLAG_BIT = 0;
    localparam int EN_BIT   = 1;
    localparam int MODE_BIT = 2;

    typedef enum logic {
        RANGE_UNSIGNED = 1'b0,
        RANGE_MID      = 1'b1
    } range_mode_e;

    typedef struct packed {
        range_mode_e mode;
        logic        en;
        logic        flag;
    } ctl_t;

    function automatic logic [RD_W-1:0] pack_read(input ctl_t c, input logic rmw);
        logic [RD_W-1:0] w;
        w           = '0;
        w[FLAG_BIT] = c.flag | rmw;
        w[EN_BIT]   = c.en;
        w[MODE_BIT] = c.mode;
        return w;
    endfunction

endpackage

// File: rtl/rcm_range_detect.sv
module rcm_range_detect
    import rcm_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         step_valid,
    input  logic         step_up,
    input  logic [W-1:0] cnt_prev,
    input  logic [W-1:0] cnt_next,
    input  range_mode_e  mode,
    output logic         hit
);
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};
    localparam logic [W-1:0] U_LO = '0;
    localparam logic [W-1:0] U_HI = '1;
    localparam logic [W-1:0] M_LO = {1'b1, {(W-1){1'b0}}};
    localparam logic [W-1:0] M_HI = {1'b0, {(W-1){1'b1}}};

    logic [W-1:0] lo, hi;
    logic         down_hit, up_hit;

    always_comb begin
        lo       = (mode == RANGE_MID) ? M_LO : U_LO;
        hi       = (mode == RANGE_MID) ? M_HI : U_HI;
        down_hit = !step_up && (cnt_prev == lo + ONE) && (cnt_next == lo);
        up_hit   =  step_up && (cnt_prev == hi - ONE) && (cnt_next == hi);
        hit      = step_valid && (down_hit || up_hit);
    end

endmodule

// File: rtl/rcm_ctl_reg.sv
module rcm_ctl_reg
    import rcm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             set_hit,
    output ctl_t             ctl_q,
    output logic             irq_q
);
    logic clr_req;

    always_comb clr_req = wr_en && !wr_data[FLAG_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
            irq_q <= 1'b0;
        end else begin
            if (wr_en) begin
                ctl_q.en   <= wr_data[EN_BIT];
                ctl_q.mode <= range_mode_e'(wr_data[MODE_BIT]);
            end
            if (set_hit)
                ctl_q.flag <= 1'b1;
            else if (clr_req)
                ctl_q.flag <= 1'b0;
            irq_q <= ctl_q.flag & ctl_q.en;
        end
    end

    // R1..R4: a detected transition leaves the flag set
    p_set_flag_r1: assert property (@(posedge clk) disable iff (rst)
        set_hit |=> ctl_q.flag);

    p_clear_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_data[FLAG_BIT] && !set_hit) |=> !ctl_q.flag);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (!set_hit && !(wr_en && !wr_data[FLAG_BIT])) |=> $stable(ctl_q.flag));

    p_set_wins_r7: assert property (@(posedge clk) disable iff (rst)
        (set_hit && wr_en && !wr_data[FLAG_BIT]) |=> ctl_q.flag);

    p_irq_lag_r9: assert property (@(posedge clk) disable iff (rst)
        ctl_q.flag && ctl_q.en |=> irq_q);

    p_irq_low_r9: assert property (@(posedge clk) disable iff (rst)
        !(ctl_q.flag && ctl_q.en) |=> !irq_q);

endmodule

// File: rtl/rev_range_monitor.sv
module rev_range_monitor
    import rcm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_valid,
    input  logic             step_up,
    input  logic [CNT_W-1:0] cnt_prev,
    input  logic [CNT_W-1:0] cnt_next,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             rmw_rd,
    output logic [RD_W-1:0]  rd_data,
    output logic             range_flag,
    output logic             irq
);
    ctl_t ctl;
    logic hit;

    rcm_range_detect #(.W(CNT_W)) u_detect (
        .step_valid (step_valid),
        .step_up    (step_up),
        .cnt_prev   (cnt_prev),
        .cnt_next   (cnt_next),
        .mode       (ctl.mode),
        .hit        (hit)
    );

    rcm_ctl_reg u_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .set_hit (hit),
        .ctl_q   (ctl),
        .irq_q   (irq)
    );

    always_comb begin
        rd_data    = pack_read(ctl, rmw_rd);
        range_flag = ctl.flag;
    end

    p_hit_strobe_r5: assert property (@(posedge clk) disable iff (rst)
        hit |-> step_valid);

    p_mode_load_r11: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (ctl.mode == range_mode_e'($past(wr_data[MODE_BIT]))));

endmodule

// File: tb/test_rev_range_monitor.sv
module test_rev_range_monitor;
    import rcm_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        step_valid = 1'b0;
    logic        step_up = 1'b0;
    logic [15:0] cnt_prev = '0;
    logic [15:0] cnt_next = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_data = '0;
    logic        rmw_rd = 1'b0;
    logic [15:0] rd_data;
    logic        range_flag;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rev_range_monitor i_rev_range_monitor (
        .clk(clk), .rst(rst), .step_valid(step_valid), .step_up(step_up),
        .cnt_prev(cnt_prev), .cnt_next(cnt_next), .wr_en(wr_en),
        .wr_data(wr_data), .rmw_rd(rmw_rd), .rd_data(rd_data),
        .range_flag(range_flag), .irq(irq)
    );

    // {mode, up, expected flag, prev, next}
    localparam logic [34:0] VEC [10] = '{
        {1'b0, 1'b0, 1'b1, 16'h0001, 16'h0000},
        {1'b0, 1'b1, 1'b1, 16'hFFFE, 16'hFFFF},
        {1'b1, 1'b0, 1'b1, 16'h8001, 16'h8000},
        {1'b1, 1'b1, 1'b1, 16'h7FFE, 16'h7FFF},
        {1'b0, 1'b1, 1'b0, 16'h0000, 16'h0001},
        {1'b0, 1'b0, 1'b0, 16'hFFFF, 16'hFFFE},
        {1'b1, 1'b0, 1'b0, 16'h0001, 16'h0000},
        {1'b0, 1'b1, 1'b0, 16'h7FFE, 16'h7FFF},
        {1'b1, 1'b1, 1'b0, 16'h8000, 16'h8001},
        {1'b0, 1'b0, 1'b0, 16'h0002, 16'h0001}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [2:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_step(input logic up, input logic [15:0] p, input logic [15:0] n);
        @(negedge clk);
        step_valid = 1'b1; step_up = up; cnt_prev = p; cnt_next = n;
        @(negedge clk);
        step_valid = 1'b0;
    endtask

    function automatic string tag_of(input logic [34:0] v);
        if (!v[32]) return "R5";
        if (v[34]) return v[33] ? "R4" : "R3";
        return v[33] ? "R2" : "R1";
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: reset state, reserved bits zero
        check("R10 read word", {16'h0, rd_data}, 32'h0);
        check("R10 irq", {31'h0, irq}, 32'h0);
        check("R10 flag", {31'h0, range_flag}, 32'h0);

        for (int i = 0; i < 10; i++) begin
            do_write({VEC[i][34], 1'b0, 1'b0});
            do_step(VEC[i][33], VEC[i][31:16], VEC[i][15:0]);
            check(tag_of(VEC[i]), {31'h0, range_flag}, {31'h0, VEC[i][32]});
        end

        // R5: matching values without the strobe
        do_write(3'b000);
        @(negedge clk);
        step_up = 1'b0; cnt_prev = 16'h0001; cnt_next = 16'h0000;
        @(negedge clk);
        check("R5 no strobe", {31'h0, range_flag}, 32'h0);

        // R6: writing 1 to a clear flag leaves it clear
        do_write(3'b001);
        check("R6 write1 clear flag", {31'h0, range_flag}, 32'h0);
        do_step(1'b0, 16'h0001, 16'h0000);
        do_write(3'b001);
        check("R6 write1 keeps set", {31'h0, range_flag}, 32'h1);
        do_write(3'b000);
        check("R6 write0 clears", {31'h0, range_flag}, 32'h0);

        // R7: set and clear in one cycle
        @(negedge clk);
        step_valid = 1'b1; step_up = 1'b1; cnt_prev = 16'hFFFE; cnt_next = 16'hFFFF;
        wr_en = 1'b1; wr_data = 3'b000;
        @(negedge clk);
        step_valid = 1'b0; wr_en = 1'b0;
        check("R7 set wins", {31'h0, range_flag}, 32'h1);

        // R8: rmw read returns 1 in bit 0
        do_write(3'b000);
        check("R8 plain read", {31'h0, rd_data[0]}, 32'h0);
        rmw_rd = 1'b1;
        #1;
        check("R8 rmw read", {31'h0, rd_data[0]}, 32'h1);
        rmw_rd = 1'b0;

        // R11: enable and mode load and read back
        do_write(3'b110);
        check("R11 readback", {16'h0, rd_data}, 32'h6);
        do_write(3'b010);
        check("R11 readback en only", {16'h0, rd_data}, 32'h2);

        // R9: irq lags flag&enable by one cycle
        do_step(1'b0, 16'h0001, 16'h0000);
        check("R9 irq not yet", {31'h0, irq}, 32'h0);
        @(negedge clk);
        check("R9 irq raised", {31'h0, irq}, 32'h1);
        do_write(3'b010);
        check("R9 irq still high", {31'h0, irq}, 32'h1);
        @(negedge clk);
        check("R9 irq dropped", {31'h0, irq}, 32'h0);
        do_step(1'b0, 16'h0001, 16'h0000);
        do_write(3'b001);
        @(negedge clk);
        check("R9 enable off", {31'h0, irq}, 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule